// File: doc/BRIEF.md
# Exception Vector Fetch Unit

This block converts an exception request into the handler's start address. A request is either a software trap with a 4-bit trap operand or an interrupt acknowledge. For an acknowledge, the requesting device supplies an 8-bit vector number, and a bus error may be flagged during that acknowledge. The block picks the vector number, multiplies it by four to form a byte address, and reads the 32-bit handler address as two 16-bit words over a ready-handshaked memory port. Every read on that port is marked as a supervisor data access.

There is no autovector path. An interrupt always uses the number supplied by the device. A bus error during the acknowledge replaces that number with the spurious-interrupt vector, number 24. When the second word arrives, the new program counter is loaded and a one-cycle done strobe is raised. Interrupt acknowledge vector numbers below 64 lie outside the user range. They are reported on an error output but are still used to form the address.

Top module: `exc_vector_fetch`

## Requirements
- R1: A trap request (`req_irq`=0) with operand n (0..15) reads from byte address (32+n)*4.
- R2: An acknowledge request (`req_irq`=1, `iack_berr`=0) with vector number v (0..255) reads from byte address v*4.
- R3: An acknowledge request with `iack_berr`=1 reads from byte address 0x060 (vector 24), whatever the supplied number. On a trap request, `iack_berr` has no effect.
- R4: The first read uses the vector address and gives bits 31:16 of the new program counter. The second read uses the vector address plus 2 and gives bits 15:0.
- R5: `mem_sd` is 1 on every cycle that `mem_req` is 1.
- R6: `done` is high for exactly one cycle. That cycle follows the clock edge on which the second word is accepted, and `pc_out` takes its new value on that same edge and changes at no other time.
- R7: `vec_err` is updated on each accepted request. It becomes 1 only for an acknowledge without a bus error whose vector number is below 64, and 0 in every other case.
- R8: A `req_valid` raised while `busy`=1 is ignored: the fetch in progress is unaffected and no further fetch starts.
- R9: After reset, `mem_req`, `done`, `busy` and `vec_err` are 0 and `pc_out` is 0.
- R10: While `mem_req`=1 and `mem_ready`=0, the request and address are held unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request, accepted when idle |
| req_irq | input | 1 | 1 = interrupt acknowledge, 0 = trap |
| trap_num | input | 4 | Trap operand |
| irq_vec | input | 8 | Vector number returned by the device |
| iack_berr | input | 1 | Bus error seen during the acknowledge |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 24 | Byte address of the word |
| mem_sd | output | 1 | Supervisor data space indication |
| mem_ready | input | 1 | Word accepted / data valid |
| mem_rdata | input | 16 | Read data |
| pc_out | output | 32 | New program counter |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Fetch in progress |
| vec_err | output | 1 | Supplied vector number below user range |

## Verification
The hardest situation to reach from the ports is a new request arriving in the middle of a fetch that is being stretched by wait states. The bench raises `req_valid` with a different trap operand during an active fetch. It then checks that the addresses read, the program counter loaded and the idle port afterwards all belong to the first request only. Every trap operand and every one of the 256 acknowledge numbers are swept, and the bus-error cases are added on top. The bench's memory model cycles through zero to two wait states and returns data computed arithmetically from the address, so a wrong word order or address shows up in the program counter.

// File: rtl/exv_pkg.sv
package exv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2
  } fetch_st_t;

  localparam int TRAP_BASE = 32;
  localparam int SPUR_VEC  = 24;
  localparam int USER_MIN  = 64;
endpackage

// File: rtl/exv_vec_select.sv
module exv_vec_select
  import exv_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int TRAP_W = 4
) (
  input  logic              req_irq,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              iack_berr,
  output logic [VEC_W-1:0]  vec_num,
  output logic              vec_low
);
  localparam logic [VEC_W-1:0] TRAP_OFS = VEC_W'(TRAP_BASE);
  localparam logic [VEC_W-1:0] SPUR     = VEC_W'(SPUR_VEC);
  localparam logic [VEC_W-1:0] UMIN     = VEC_W'(USER_MIN);

  always_comb begin
    vec_low = 1'b0;
    if (!req_irq) begin
      vec_num = TRAP_OFS + VEC_W'(trap_num);
    end else if (iack_berr) begin
      vec_num = SPUR;
    end else begin
      vec_num = irq_vec;
      vec_low = (irq_vec < UMIN);
    end
  end
endmodule

// File: rtl/exv_fetch_fsm.sv
module exv_fetch_fsm
  import exv_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [VEC_W-1:0]    vec_num,
  input  logic                mem_ready,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_sd,
  output logic [2*WORD_W-1:0] pc_out,
  output logic                done,
  output logic                busy
);
  localparam int PAD_W = ADDR_W - VEC_W - 2;

  fetch_st_t           st_q, st_d;
  logic [ADDR_W-1:0]   base_q;
  logic [WORD_W-1:0]   hi_q;
  logic [2*WORD_W-1:0] pc_q;
  logic                done_q, done_d;
  logic                hi_en, pc_en;

  always_comb begin
    st_d   = st_q;
    hi_en  = 1'b0;
    pc_en  = 1'b0;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_HI;
      ST_HI: if (mem_ready) begin
        hi_en = 1'b1;
        st_d  = ST_LO;
      end
      ST_LO: if (mem_ready) begin
        pc_en  = 1'b1;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      hi_q   <= '0;
      pc_q   <= '0;
    end else begin
      if (start && st_q == ST_IDLE) base_q <= {{PAD_W{1'b0}}, vec_num, 2'b00};
      if (hi_en) hi_q <= mem_rdata;
      if (pc_en) pc_q <= {hi_q, mem_rdata};
    end
  end

  assign mem_req  = (st_q != ST_IDLE);
  assign mem_sd   = (st_q == ST_HI) || (st_q == ST_LO);
  assign mem_addr = {base_q[ADDR_W-1:2], st_q == ST_LO, 1'b0};
  assign pc_out   = pc_q;
  assign done     = done_q;
  assign busy     = (st_q != ST_IDLE);

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R10
  AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HI && mem_ready) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(2))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_PC_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(pc_out) || done)); // R6
  AST_SD_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_sd); // R5
endmodule

// File: rtl/exc_vector_fetch.sv
module exc_vector_fetch
  import exv_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 8,
  parameter int TRAP_W = 4,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_irq,
  input  logic [TRAP_W-1:0]   trap_num,
  input  logic [VEC_W-1:0]    irq_vec,
  input  logic                iack_berr,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_sd,
  input  logic                mem_ready,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [2*WORD_W-1:0] pc_out,
  output logic                done,
  output logic                busy,
  output logic                vec_err
);
  logic [VEC_W-1:0] vec_num;
  logic             vec_low;
  logic             start;
  logic             vec_err_q;

  exv_vec_select #(.VEC_W(VEC_W), .TRAP_W(TRAP_W)) u_sel (
    .req_irq   (req_irq),
    .trap_num  (trap_num),
    .irq_vec   (irq_vec),
    .iack_berr (iack_berr),
    .vec_num   (vec_num),
    .vec_low   (vec_low)
  );

  assign start = req_valid && !busy;

  exv_fetch_fsm #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .WORD_W(WORD_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vec_num   (vec_num),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_sd    (mem_sd),
    .pc_out    (pc_out),
    .done      (done),
    .busy      (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_err_q <= 1'b0;
    else if (start) vec_err_q <= vec_low;
  end

  assign vec_err = vec_err_q;

  AST_START_BEGINS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_req && mem_addr[1:0] == 2'b00)); // R4
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(vec_err)); // R8
endmodule

// File: tb/tb_exc_vector_fetch.sv
module tb_exc_vector_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_irq = 1'b0;
  logic [3:0]  trap_num = '0;
  logic [7:0]  irq_vec = '0;
  logic        iack_berr = 1'b0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_sd;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [31:0] pc_out;
  logic        done;
  logic        busy;
  logic        vec_err;

  int errors = 0;
  int checks = 0;
  int wcnt = 0;
  int wtgt = 0;
  int nseen = 0;
  int nreq = 0;
  logic [23:0] seen [0:1];
  bit sd_bad = 0;

  always #4 clk = ~clk;

  exc_vector_fetch dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_irq(req_irq),
    .trap_num(trap_num), .irq_vec(irq_vec), .iack_berr(iack_berr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_sd(mem_sd),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .done(done), .busy(busy), .vec_err(vec_err)
  );

  function automatic logic [15:0] fmem(input logic [23:0] a);
    return a[15:0] * 16'd3 + 16'h1234;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Memory model with 0..2 wait states, data derived from the address.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= wtgt) begin
        mem_ready = 1'b1;
        mem_rdata = fmem(mem_addr);
        if (nseen < 2) seen[nseen] = mem_addr;
        nseen++;
        if (!mem_sd) sd_bad = 1;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic run_req(input bit irq, input logic [3:0] tn, input logic [7:0] v,
                         input bit berr, input int exp_vec, input bit exp_err,
                         input string tag, input bit inject);
    logic [23:0] ea;
    logic [31:0] epc;
    logic [31:0] pc0;
    bit got;
    ea  = 24'(exp_vec * 4);
    epc = {fmem(ea), fmem(ea + 24'd2)};
    @(negedge clk);
    nseen = 0;
    sd_bad = 0;
    wtgt = nreq % 3;
    nreq++;
    pc0 = pc_out;
    req_valid = 1'b1; req_irq = irq; trap_num = tn; irq_vec = v; iack_berr = berr;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    for (int i = 0; i < 64; i++) begin
      if (inject && i == 1) begin
        // R8: new request while busy, with a different trap operand
        req_valid = 1'b1; req_irq = 1'b0; trap_num = tn + 4'd5; iack_berr = 1'b0;
      end else begin
        req_valid = 1'b0;
      end
      if (done) begin
        got = 1;
        break;
      end
      if (pc_out !== pc0) begin
        check(0, "R6 pc changed before done", pc_out, pc0);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(got, {"R6 done seen ", tag}, got, 1);
    check(nseen == 2, {"R4 word count ", tag}, nseen, 2);
    check(seen[0] == ea, {tag, " first address"}, seen[0], ea);
    check(seen[1] == ea + 24'd2, {"R4 second address ", tag}, seen[1], ea + 24'd2);
    check(pc_out == epc, {"R4 pc ", tag}, pc_out, epc);
    check(!sd_bad, {"R5 sd ", tag}, sd_bad, 0);
    check(vec_err == exp_err, {"R7 vec_err ", tag}, vec_err, exp_err);
    @(negedge clk);
    check(done == 1'b0, {"R6 done single cycle ", tag}, done, 0);
    if (inject) begin
      @(negedge clk);
      @(negedge clk);
      check(mem_req == 1'b0 && nseen == 2, "R8 no fetch after busy request", mem_req, 0);
      check(pc_out == epc, "R8 pc unaffected", pc_out, epc);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_req == 0 && done == 0 && busy == 0, "R9 reset outputs", {mem_req, done, busy}, 0);
    check(pc_out == 0 && vec_err == 0, "R9 reset pc/err", pc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 16; n++)
      run_req(0, 4'(n), 8'h00, 0, 32 + n, 0, "R1 trap", 0);
    for (int v = 0; v < 256; v++)
      run_req(1, 4'd0, 8'(v), 0, v, v < 64, "R2 irq", 0);
    run_req(1, 4'd0, 8'd200, 1, 24, 0, "R3 berr", 0);
    run_req(1, 4'd0, 8'd5, 1, 24, 0, "R3 berr low", 0);
    run_req(1, 4'd0, 8'd255, 1, 24, 0, "R3 berr max", 0);
    run_req(0, 4'd7, 8'd99, 1, 39, 0, "R3 trap ignores berr", 0);
    run_req(0, 4'd2, 8'd0, 0, 34, 0, "R8 trap", 1);
    run_req(1, 4'd0, 8'd10, 0, 10, 1, "R8 irq low", 1);
    run_req(1, 4'd0, 8'd128, 0, 128, 0, "R10 waits", 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule